// File: doc/BRIEF.md
# Video Timing Measurement Unit

The unit sits on an incoming pixel stream and works out its timing. It takes hsync, vsync and data enable in the pixel-clock domain. It measures the horizontal and vertical geometry, and it counts the cycles of a slower reference clock across each frame so that software can derive the pixel rate. Software reads the results byte by byte through a small read port. Multi-byte fields are laid out least significant byte first at rising addresses.

The active level of each sync is learned rather than configured. The unit records the length of the latest complete high run and the latest complete low run of each sync. The shorter of the two is taken as the pulse, and the sync is normalised to active-high inside the unit. Vertical porches, sync width and total are counted in pixel clocks, not lines, so that sub-line offsets are visible. The measurement counters run all the time. Every result is copied into the readable snapshot in the same cycle, at the start of the active vsync pulse. A read therefore never mixes values from two frames.

Top module: `video_timing_meter`

## Requirements
- R1: After reset every address reads 0x00. All results, the status byte included, stay zero until one complete frame has been measured. A complete frame runs from one active-vsync start to the next, with both polarities already settled.
- R2: The active level of each sync is its shorter level, judged from that sync's most recent complete high run and low run. Status byte 0x18 holds: bit 0 = hsync is active-high, bit 1 = vsync is active-high, bit 2 = results valid, bits 7:3 = zero.
- R3: Horizontal active width (0x00-0x01) is the number of pixels with DE high in the last line that contained DE. Horizontal total (0x04-0x05) is the number of pixel clocks from one hsync start to the next.
- R4: The 8-bit horizontal fields are: front porch (0x09), from the end of DE to the next hsync start; back porch (0x0A), from the end of hsync to the start of DE; sync width (0x0B). Each saturates at 255.
- R5: Vertical active (0x02-0x03) is the count of DE rising edges in the frame, which is the number of lines with DE. Vertical total (0x06-0x08) is the number of pixel clocks from one vsync start to the next.
- R6: The vertical fields, all in pixel clocks, are: front porch (0x0C-0x0E), from the last DE end of the frame to the next vsync start; back porch (0x0F-0x11), from the end of vsync to the first DE of the frame; sync width (0x12-0x14).
- R7: Field 0x15-0x17 counts the rising edges of the reference clock, resynchronised into the pixel domain, during the frame. The reference clock must run below half the pixel rate.
- R8: rd_data carries the byte at rd_addr one pixel clock after rd_addr is presented. Within a field the lowest address holds the least significant byte. Addresses 0x19 and above read 0x00.
- R9: All results are captured together at the start of active vsync. Between captures the read values do not change, even if the stream stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the whole unit runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| de_in | input | 1 | Data enable, high on active pixels |
| ref_clk_in | input | 1 | Slow reference clock, sampled asynchronously |
| rd_addr | input | ADDR_W | Byte address of the result to read |
| rd_data | output | 8 | Byte read from rd_addr, one cycle later |

## Verification
The hardest state to reach from the ports is a settled measurement after the sync polarities change. Both syncs must first show a complete run at each level. After that, one full frame must pass before a capture, so the stimulus lets several whole frames run before any value is compared. The bench switches between three timings that have different polarities. One of them has a back porch longer than 255 pixels, which drives the 8-bit saturation. The bench also stops the stream after a capture to show that the snapshot holds. It resets the unit in the middle of a frame and reads the zero state again.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

    localparam int HW = 16;   // horizontal count width
    localparam int LW = 16;   // line count width
    localparam int VW = 24;   // vertical pixel-clock count width
    localparam int PW = 8;    // horizontal porch / sync width
    localparam int RW = 24;   // reference-clock count width

    // first member is most significant: h_act lands at byte 0
    typedef struct packed {
        logic [RW-1:0] ref_cnt;
        logic [VW-1:0] v_sw;
        logic [VW-1:0] v_bp;
        logic [VW-1:0] v_fp;
        logic [PW-1:0] h_sw;
        logic [PW-1:0] h_bp;
        logic [PW-1:0] h_fp;
        logic [VW-1:0] v_tot;
        logic [HW-1:0] h_tot;
        logic [LW-1:0] v_act;
        logic [HW-1:0] h_act;
    } vtm_meas_t;

    localparam int MEAS_BYTES = $bits(vtm_meas_t) / 8;
    localparam int NB         = MEAS_BYTES + 1;   // plus status byte

    function automatic logic [PW-1:0] sat_pw(input logic [HW-1:0] v);
        return (|v[HW-1:PW]) ? {PW{1'b1}} : v[PW-1:0];
    endfunction

endpackage

// File: rtl/vtm_sync_pol.sv
module vtm_sync_pol #(
    parameter int CW = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic active,
    output logic pol_high,
    output logic known
);

    typedef struct packed {
        logic          lvl;
        logic          started;
        logic [CW-1:0] run;
        logic [CW-1:0] hi_len;
        logic [CW-1:0] lo_len;
        logic          seen_hi;
        logic          seen_lo;
    } st_t;

    st_t q, d;

    always_comb begin
        d     = q;
        d.lvl = raw;
        if (raw != q.lvl) begin
            if (q.started) begin
                if (q.lvl) begin
                    d.hi_len  = q.run;
                    d.seen_hi = 1'b1;
                end else begin
                    d.lo_len  = q.run;
                    d.seen_lo = 1'b1;
                end
            end
            d.started = 1'b1;
            d.run     = {{(CW-1){1'b0}}, 1'b1};
        end else if (q.run != {CW{1'b1}}) begin
            d.run = q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign known    = q.seen_hi & q.seen_lo;
    assign pol_high = q.hi_len < q.lo_len;
    assign active   = pol_high ? q.lvl : ~q.lvl;

    assert_known_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        known |=> known);

    assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.started |-> (q.run != '0));

endmodule

// File: rtl/vtm_measure.sv
module vtm_measure
    import vtm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      hs_a,
    input  logic      vs_a,
    input  logic      de,
    input  logic      ref_rise,
    output logic      frame_done,
    output vtm_meas_t meas
);

    typedef struct packed {
        logic          hs_p, vs_p, de_p;
        logic          l_open, l_hse_seen, l_de_seen;
        logic [HW-1:0] lpos, l_hse, l_def, l_dee;
        logic [HW-1:0] h_tot, h_act;
        logic [PW-1:0] h_fp, h_bp, h_sw;
        logic          f_open, f_vse_seen, f_de_seen;
        logic [VW-1:0] fpos, f_vse, f_def, f_dee;
        logic [LW-1:0] v_lines;
        logic [RW-1:0] refs;
    } st_t;

    st_t q, d;
    logic          line_start, frame_start;
    logic [HW-1:0] cur_l;
    logic [VW-1:0] cur_f;

    always_comb begin
        line_start  = hs_a & ~q.hs_p;
        frame_start = vs_a & ~q.vs_p;
        cur_l       = line_start  ? '0 : q.lpos;
        cur_f       = frame_start ? '0 : q.fpos;
        frame_done  = en & frame_start & q.f_open;

        meas.h_act   = q.h_act;
        meas.h_tot   = q.h_tot;
        meas.h_fp    = q.h_fp;
        meas.h_bp    = q.h_bp;
        meas.h_sw    = q.h_sw;
        meas.v_act   = q.v_lines;
        meas.v_tot   = q.fpos;
        meas.v_fp    = q.fpos - q.f_dee;
        meas.v_bp    = q.f_def - q.f_vse;
        meas.v_sw    = q.f_vse;
        meas.ref_cnt = q.refs;

        d = q;
        if (!en) begin
            d = '0;
        end else begin
            // line boundary: close the finished line first
            if (line_start) begin
                if (q.l_open && q.l_de_seen) begin
                    d.h_tot = q.lpos;
                    d.h_act = q.l_dee - q.l_def;
                    d.h_fp  = sat_pw(q.lpos - q.l_dee);
                    d.h_bp  = sat_pw(q.l_def - q.l_hse);
                    d.h_sw  = sat_pw(q.l_hse);
                end
                d.l_open     = 1'b1;
                d.l_hse_seen = 1'b0;
                d.l_de_seen  = 1'b0;
                d.lpos       = {{(HW-1){1'b0}}, 1'b1};
            end else if (q.lpos != {HW{1'b1}}) begin
                d.lpos = q.lpos + 1'b1;
            end

            // frame boundary
            if (frame_start) begin
                d.f_open     = 1'b1;
                d.f_vse_seen = 1'b0;
                d.f_de_seen  = 1'b0;
                d.v_lines    = '0;
                d.refs       = '0;
                d.fpos       = {{(VW-1){1'b0}}, 1'b1};
            end else if (q.fpos != {VW{1'b1}}) begin
                d.fpos = q.fpos + 1'b1;
            end

            // events of the current cycle
            if (!hs_a && q.hs_p && !d.l_hse_seen) begin
                d.l_hse      = cur_l;
                d.l_hse_seen = 1'b1;
            end
            if (!vs_a && q.vs_p && !d.f_vse_seen) begin
                d.f_vse      = cur_f;
                d.f_vse_seen = 1'b1;
            end
            if (de && !q.de_p) begin
                if (!d.l_de_seen) begin
                    d.l_def     = cur_l;
                    d.l_de_seen = 1'b1;
                end
                if (!d.f_de_seen) begin
                    d.f_def     = cur_f;
                    d.f_de_seen = 1'b1;
                end
                if (d.v_lines != {LW{1'b1}}) d.v_lines = d.v_lines + 1'b1;
            end
            if (!de && q.de_p) begin
                d.l_dee = cur_l;
                d.f_dee = cur_f;
            end
            if (ref_rise && d.refs != {RW{1'b1}}) d.refs = d.refs + 1'b1;
        end

        d.hs_p = hs_a;
        d.vs_p = vs_a;
        d.de_p = de;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_hact_in_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && line_start && q.l_open && q.l_de_seen && q.l_dee >= q.l_def)
            |=> (q.h_act <= q.h_tot));

endmodule

// File: rtl/vtm_regs.sv
module vtm_regs
    import vtm_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  vtm_meas_t     meas,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int IMG_W = 8 * NB;

    typedef struct packed {
        vtm_meas_t  snap;
        logic       hpol;
        logic       vpol;
        logic       valid;
        logic [7:0] rd;
    } st_t;

    st_t q, d;
    logic [IMG_W-1:0] image;
    logic             addr_oob;

    assign image    = {5'b00000, q.valid, q.vpol, q.hpol, q.snap};
    assign addr_oob = int'(rd_addr) >= NB;

    always_comb begin
        int idx;
        d   = q;
        idx = int'(rd_addr);
        if (cap) begin
            d.snap  = meas;
            d.hpol  = hs_pol;
            d.vpol  = vs_pol;
            d.valid = 1'b1;
        end
        if (addr_oob) d.rd = 8'h00;
        else          d.rd = image[idx*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.rd;

    assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> q.valid);

    assert_zero_until_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> (q.snap == '0 && !q.hpol && !q.vpol));

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q.snap));

    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oob |=> (rd_data == 8'h00));

endmodule

// File: rtl/video_timing_meter.sv
module video_timing_meter
    import vtm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              de_in,
    input  logic              ref_clk_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int SYNC_STAGES = 3;   // two resync flops plus edge flop

    typedef struct packed {
        logic                   de_q;
        logic [SYNC_STAGES-1:0] ref_s;
    } st_t;

    st_t q, d;
    logic      hs_a, vs_a, hs_high, vs_high, hs_known, vs_known;
    logic      en, ref_rise, frame_done;
    vtm_meas_t meas;

    always_comb begin
        d       = q;
        d.de_q  = de_in;
        d.ref_s = {q.ref_s[SYNC_STAGES-2:0], ref_clk_in};
    end

    always_ff @(posedge pix_clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ref_rise = q.ref_s[SYNC_STAGES-2] & ~q.ref_s[SYNC_STAGES-1];
    assign en       = hs_known & vs_known;

    vtm_sync_pol #(.CW(VW)) u_hs_pol (
        .clk      (pix_clk),
        .rst_n    (rst_n),
        .raw      (hsync_in),
        .active   (hs_a),
        .pol_high (hs_high),
        .known    (hs_known)
    );

    vtm_sync_pol #(.CW(VW)) u_vs_pol (
        .clk      (pix_clk),
        .rst_n    (rst_n),
        .raw      (vsync_in),
        .active   (vs_a),
        .pol_high (vs_high),
        .known    (vs_known)
    );

    vtm_measure u_measure (
        .clk        (pix_clk),
        .rst_n      (rst_n),
        .en         (en),
        .hs_a       (hs_a),
        .vs_a       (vs_a),
        .de         (q.de_q),
        .ref_rise   (ref_rise),
        .frame_done (frame_done),
        .meas       (meas)
    );

    vtm_regs #(.AW(ADDR_W)) u_regs (
        .clk     (pix_clk),
        .rst_n   (rst_n),
        .cap     (frame_done),
        .meas    (meas),
        .hs_pol  (hs_high),
        .vs_pol  (vs_high),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assert_ref_rise_gap_R7: assert property (@(posedge pix_clk) disable iff (!rst_n)
        ref_rise |=> !ref_rise);

    assert_capture_needs_lock_R1: assert property (@(posedge pix_clk) disable iff (!rst_n)
        frame_done |-> (hs_known && vs_known));

endmodule

// File: tb/video_timing_meter_bench.sv
module video_timing_meter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0, ref_clk_in = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    video_timing_meter u_video_timing_meter (
        .pix_clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .ref_clk_in(ref_clk_in), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // stream mode
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
    bit hpol, vpol;
    bit video_on = 0;
    int frame_cnt = 0;

    // reference clock: period of six pixel clocks
    int refdiv = 0;
    always @(negedge clk) begin
        refdiv++;
        if (refdiv == 3) begin refdiv = 0; ref_clk_in = ~ref_clk_in; end
    end

    // video generator
    initial begin
        forever begin
            if (!video_on) begin
                @(negedge clk);
                hsync_in = ~hpol; vsync_in = ~vpol; de_in = 1'b0;
            end else begin
                int ht, vl, a0, l0;
                ht = hsw + hbp + hact + hfp;
                vl = vsw + vbp + vact + vfp;
                a0 = hsw + hbp;
                l0 = vsw + vbp;
                for (int ln = 0; ln < vl; ln++) begin
                    for (int p = 0; p < ht; p++) begin
                        @(negedge clk);
                        hsync_in = (p < hsw) ? hpol : ~hpol;
                        vsync_in = (ln < vsw) ? vpol : ~vpol;
                        de_in    = (ln >= l0 && ln < l0 + vact && p >= a0 && p < a0 + hact);
                    end
                end
                frame_cnt++;
            end
        end
    end

    // scoreboard
    typedef struct {
        int         addr;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sbq[$];

    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h",
                         it.req, it.addr, rd_data, it.exp);
            end
        end
    end

    task automatic rd_check(input int a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        rd_addr = 6'(a);
        it.addr = a; it.exp = e; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic drain();
        wait (sbq.size() == 0);
        @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frame_cnt + n;
        wait (frame_cnt >= target);
    endtask

    function automatic int sat8(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic string req_of(input int a);
        if (a <= 1 || a == 4 || a == 5) return "R3";
        if (a <= 8)  return "R5";
        if (a <= 11) return "R4";
        if (a <= 20) return "R6";
        if (a <= 23) return "R7";
        return "R2";
    endfunction

    // expected image from the stated address map
    function automatic logic [7:0] exp_byte(input int a);
        int ht, vt, last_end;
        logic [8*NBYTES-1:0] img;
        ht = hsw + hbp + hact + hfp;
        vt = (vsw + vbp + vact + vfp) * ht;
        last_end = (vsw + vbp + vact - 1) * ht + hsw + hbp + hact;
        img = {5'b00000, 1'b1, vpol, hpol,
               24'(vt / 6),
               24'(vsw * ht),
               24'(vbp * ht + hsw + hbp),
               24'(vt - last_end),
               8'(sat8(hsw)), 8'(sat8(hbp)), 8'(sat8(hfp)),
               24'(vt), 16'(ht), 16'(vact), 16'(hact)};
        if (a >= NBYTES) return 8'h00;
        return img[a*8 +: 8];
    endfunction

    task automatic check_all(input string tag_all);
        for (int a = 0; a < NBYTES; a++)
            rd_check(a, exp_byte(a), (tag_all == "") ? req_of(a) : tag_all);
        rd_check(6'h19, 8'h00, "R8");
        rd_check(6'h3F, 8'h00, "R8");
        drain();
    endtask

    task automatic check_zero(input string req);
        for (int a = 0; a < NBYTES; a++) rd_check(a, 8'h00, req);
        drain();
    endtask

    task automatic set_mode(input int a, b, c, e, f, g, h, i, input bit hp, vp);
        hsw = a; hbp = b; hact = c; hfp = e;
        vsw = f; vbp = g; vact = h; vfp = i;
        hpol = hp; vpol = vp;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        set_mode(4, 6, 20, 6, 2, 3, 8, 2, 1'b1, 1'b1);   // 36 x 15 lines = 540
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: zero after reset and before a complete frame
        check_zero("R1");
        video_on = 1;
        wait_frames(2);
        rd_check(24, 8'h00, "R1");      // status still clear
        rd_check(0, 8'h00, "R1");
        drain();

        // mode 1: both syncs active-high
        wait_frames(4);
        check_all("");

        // R9: stream stops, snapshot holds
        video_on = 0;
        wait (frame_cnt >= 0);
        repeat (2000) @(negedge clk);
        check_all("R9");

        // mode 2: active-low hsync, active-high vsync
        set_mode(8, 4, 40, 8, 3, 2, 10, 3, 1'b0, 1'b1);  // 60 x 18 = 1080
        video_on = 1;
        wait_frames(6);
        check_all("");

        // mode 3: back porch beyond 8 bits, active-low vsync
        set_mode(3, 300, 10, 5, 1, 1, 2, 1, 1'b1, 1'b0); // 318 x 5 = 1590
        wait_frames(7);
        check_all("");
        rd_check(10, 8'hFF, "R4");       // saturated back porch
        drain();

        // R1: reset in mid-frame clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_zero("R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule